// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the memory side of a two-wire serial EEPROM. It watches the host's clock and data lines, already synchronized to the system clock. It finds start and stop conditions and takes in a control byte. Bit 0 of that byte picks a write or a read. The byte array is held inside the block and holds 2^ADDR_W bytes.

The width parameter decides how the word address is delivered:
- Small arrays take the whole address from the control byte.
- Mid-size arrays take the top three address bits from the control byte and one more byte from the bus.
- Large arrays take two address bytes.

The slave pulls the data line low in every acknowledge slot. It stores write data as each byte completes and sends read data MSB first. The line the host sees is the wired-AND of both drivers.

A read keeps going until the host issues a stop condition. The address steps by one after every data byte and wraps at the array size.

Top module: `ee2w_slave`

## Requirements
- R1: After reset the block is idle, `slave_sda` is 1, and `bus_sda` follows `sda_in`.
- R2: A start condition moves the block to control-byte reception and sets `slave_sda` to 1 on the next clock. A start condition is `sda_in` going 1 to 0 while `scl_in` stays 1.
- R3: A stop condition returns the block to idle and sets `slave_sda` to 1. A stop condition is `sda_in` going 0 to 1 while `scl_in` stays 1. In idle, SCL pulses give no acknowledge, and a byte broken off by a stop is not stored.
- R4: Incoming bits are taken on SCL rising edges, MSB first, 8 per byte. `slave_sda` changes only after an SCL falling edge, a start condition or a stop condition.
- R5: `slave_sda` is 0 for the SCL pulse that follows each received byte: the control byte, each address byte and each write byte. It is also 0 during the acknowledge slot after each read byte.
- R6: When control bit 0 is 1, the byte at the current address is sent MSB first, one bit per SCL falling edge. The host's acknowledge bit is ignored, and the next byte always follows.
- R7: With ADDR_W below 8, the word address is control bits 7:1. A write goes straight to data with no address byte, and a read uses the same address field.
- R8: With ADDR_W from 8 to 11, control bits 3:1 give address bits 10:8. One low address byte follows, and the result is masked to ADDR_W bits. A read with no address phase uses the current address.
- R9: With ADDR_W of 12 or more, a high address byte and then a low address byte follow the control byte. The combined address is masked to ADDR_W bits.
- R10: A write byte is stored at the current address when its 8th bit arrives. After each data acknowledge slot the address increases by one, modulo 2^ADDR_W, for both reads and writes.
- R11: `bus_sda` is the AND of `sda_in` and `slave_sda`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Host serial clock, synchronized |
| sda_in | input | 1 | Host data drive, synchronized |
| slave_sda | output | 1 | Slave data drive (1 = released) |
| bus_sda | output | 1 | Resolved wired-AND data line |

## Verification
A wrong phase or bit count shows up at the next acknowledge slot. The data line is then released where it should be low, or held low in a data slot, within one byte time. A wrong address phase or a bad increment does not show up at once. It only becomes visible when the bytes are read back, where they arrive with the wrong value or in the wrong order. So every write is followed by a random or current-address read, and the wrap cases sit at the top of each array size. Start and stop recovery can be seen at the port one clock after the condition, because `slave_sda` must return to 1.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_WR,
        ST_WR_ACK
    } ee_state_e;

    typedef enum logic [1:0] {
        AM_IN_CTRL,   // whole address inside control byte
        AM_ONE_BYTE,  // 3 bits in control byte + one address byte
        AM_TWO_BYTE   // two address bytes
    } addr_mode_e;

    function automatic addr_mode_e mode_of(input int aw);
        if (aw < 8)       return AM_IN_CTRL;
        else if (aw < 12) return AM_ONE_BYTE;
        else              return AM_TWO_BYTE;
    endfunction

endpackage

// File: rtl/ee2w_edge.sv
module ee2w_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_in;
        prev_d.sda = sda_in;
        scl_rise   = scl_in & ~prev_q.scl;
        scl_fall   = ~scl_in & prev_q.scl;
        start_det  = scl_in & prev_q.scl & prev_q.sda & ~sda_in;
        stop_det   = scl_in & prev_q.scl & ~prev_q.sda & sda_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/ee2w_mem.sv
module ee2w_mem #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic slave_sda,
    output logic bus_sda
);
    localparam addr_mode_e MODE = mode_of(ADDR_W);
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef struct packed {
        ee_state_e         state;
        logic [3:0]        cnt;
        logic [7:0]        shreg;
        logic [ADDR_W-1:0] addr;
        logic              sda_drv;
    } core_t;

    core_t r_d, r_q;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_raddr;
    logic [7:0]        mem_rdata;
    logic [7:0]        shin;
    logic [3:0]        cnt_obs;

    ee2w_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    ee2w_mem #(.AW(ADDR_W)) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .waddr(r_q.addr),
        .wdata(shin),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    always_comb begin
        shin = {r_q.shreg[6:0], sda_in};
        if (r_q.state == ST_RD_ACK)
            mem_raddr = r_q.addr + ADDR_ONE;
        else if (MODE == AM_IN_CTRL)
            mem_raddr = ADDR_W'(r_q.shreg[7:1]);
        else
            mem_raddr = r_q.addr;
    end

    always_comb begin
        r_d    = r_q;
        mem_we = 1'b0;
        if (stop_det) begin
            r_d.state   = ST_IDLE;
            r_d.sda_drv = 1'b1;
        end else if (start_det) begin
            r_d.state   = ST_CTRL;
            r_d.sda_drv = 1'b1;
            r_d.cnt     = BITS_PER_BYTE;
        end else if (scl_rise) begin
            unique case (r_q.state)
                ST_CTRL, ST_AHI, ST_ALO, ST_WR: begin
                    r_d.shreg = shin;
                    r_d.cnt   = r_q.cnt - 4'd1;
                    if (r_q.cnt == 4'd1) begin
                        unique case (r_q.state)
                            ST_CTRL: r_d.state = ST_CTRL_ACK;
                            ST_AHI: begin
                                r_d.addr  = ADDR_W'({shin, 8'h00});
                                r_d.state = ST_AHI_ACK;
                            end
                            ST_ALO: begin
                                r_d.addr  = r_q.addr | ADDR_W'(shin);
                                r_d.state = ST_ALO_ACK;
                            end
                            default: begin
                                mem_we    = 1'b1;
                                r_d.state = ST_WR_ACK;
                            end
                        endcase
                    end
                end
                ST_CTRL_ACK: begin
                    r_d.cnt = BITS_PER_BYTE;
                    if (r_q.shreg[0]) begin
                        r_d.state = ST_RD;
                        if (MODE == AM_IN_CTRL) r_d.addr = ADDR_W'(r_q.shreg[7:1]);
                        r_d.shreg = mem_rdata;
                    end else if (MODE == AM_IN_CTRL) begin
                        r_d.addr  = ADDR_W'(r_q.shreg[7:1]);
                        r_d.state = ST_WR;
                    end else if (MODE == AM_ONE_BYTE) begin
                        r_d.addr  = ADDR_W'({r_q.shreg[3:1], 8'h00});
                        r_d.state = ST_ALO;
                    end else begin
                        r_d.state = ST_AHI;
                    end
                end
                ST_AHI_ACK: begin
                    r_d.state = ST_ALO;
                    r_d.cnt   = BITS_PER_BYTE;
                end
                ST_ALO_ACK: begin
                    r_d.state = ST_WR;
                    r_d.cnt   = BITS_PER_BYTE;
                end
                ST_RD: begin
                    r_d.cnt = r_q.cnt - 4'd1;
                    if (r_q.cnt == 4'd1) r_d.state = ST_RD_ACK;
                end
                ST_RD_ACK: begin
                    r_d.state = ST_RD;
                    r_d.cnt   = BITS_PER_BYTE;
                    r_d.addr  = r_q.addr + ADDR_ONE;
                    r_d.shreg = mem_rdata;
                end
                ST_WR_ACK: begin
                    r_d.state = ST_WR;
                    r_d.cnt   = BITS_PER_BYTE;
                    r_d.addr  = r_q.addr + ADDR_ONE;
                end
                default: ;
            endcase
        end else if (scl_fall) begin
            unique case (r_q.state)
                ST_CTRL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_RD_ACK, ST_WR_ACK:
                    r_d.sda_drv = 1'b0;
                ST_RD: begin
                    r_d.sda_drv = r_q.shreg[7];
                    r_d.shreg   = {r_q.shreg[6:0], 1'b0};
                end
                default: r_d.sda_drv = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.cnt     <= '0;
            r_q.shreg   <= '0;
            r_q.addr    <= '0;
            r_q.sda_drv <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign slave_sda = r_q.sda_drv;
    assign bus_sda   = sda_in & r_q.sda_drv;
    assign cnt_obs   = r_q.cnt;
endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       sda_in,
    input logic       slave_sda,
    input logic [3:0] cnt
);
    logic scl_p, sda_p, ev_q;
    logic start_c, stop_c, fall_c;

    assign start_c = scl_in & scl_p & sda_p & ~sda_in;
    assign stop_c  = scl_in & scl_p & ~sda_p & sda_in;
    assign fall_c  = ~scl_in & scl_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
            ev_q  <= 1'b0;
        end else begin
            scl_p <= scl_in;
            sda_p <= sda_in;
            ev_q  <= start_c | stop_c | fall_c;
        end
    end

    p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> slave_sda);

    p_stop_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> slave_sda);

    // R4: the slave line only moves after a clock fall or a bus condition
    p_sda_moves_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slave_sda) |-> ev_q);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 4'd8);
endmodule

bind ee2w_slave ee2w_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .slave_sda(slave_sda),
    .cnt      (cnt_obs)
);

// File: tb/ee2w_slave_tb.sv
module ee2w_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h [3];
    logic sda_h [3];
    logic w_slave [3];
    logic w_bus [3];
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk; // 50 MHz

    ee2w_slave #(.ADDR_W(9)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h[0]), .sda_in(sda_h[0]),
        .slave_sda(w_slave[0]), .bus_sda(w_bus[0]));
    ee2w_slave #(.ADDR_W(7)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h[1]), .sda_in(sda_h[1]),
        .slave_sda(w_slave[1]), .bus_sda(w_bus[1]));
    ee2w_slave #(.ADDR_W(12)) u_dut_large (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h[2]), .sda_in(sda_h[2]),
        .slave_sda(w_slave[2]), .bus_sda(w_bus[2]));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start(input int d);
        sda_h[d] = 1'b1; tick(2);
        scl_h[d] = 1'b1; tick(2);
        sda_h[d] = 1'b0; tick(2);
        scl_h[d] = 1'b0; tick(2);
    endtask

    task automatic bus_stop(input int d);
        sda_h[d] = 1'b0; tick(2);
        scl_h[d] = 1'b1; tick(2);
        sda_h[d] = 1'b1; tick(2);
    endtask

    task automatic send_bits(input int d, input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_h[d] = b[i]; tick(2);
            scl_h[d] = 1'b1; tick(2);
            scl_h[d] = 1'b0; tick(2);
        end
    endtask

    task automatic send_byte(input int d, input logic [7:0] b, output logic ack);
        send_bits(d, b, 8);
        sda_h[d] = 1'b1; tick(2);
        scl_h[d] = 1'b1; tick(1);
        ack = w_bus[d];
        tick(1);
        scl_h[d] = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input int d, input logic host_ack,
                             output logic [7:0] b, output logic slot);
        sda_h[d] = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2);
            scl_h[d] = 1'b1; tick(1);
            b[i] = w_bus[d];
            tick(1);
            scl_h[d] = 1'b0;
        end
        tick(1);
        sda_h[d] = host_ack; tick(2);
        scl_h[d] = 1'b1; tick(1);
        slot = w_slave[d];
        tick(1);
        scl_h[d] = 1'b0; tick(1);
        sda_h[d] = 1'b1; tick(1);
    endtask

    task automatic t_reset();
        for (int d = 0; d < 3; d++) check("R1 slave released after reset", w_slave[d], 1);
        scl_h[0] = 1'b0; tick(2);
        sda_h[0] = 1'b0; tick(2);
        check("R11 bus follows host low", w_bus[0], 0);
        check("R1 slave stays released", w_slave[0], 1);
        sda_h[0] = 1'b1; tick(2);
        check("R11 bus follows host high", w_bus[0], 1);
        scl_h[0] = 1'b1; tick(2);
    endtask

    task automatic t_mid_write();
        logic a;
        bus_start(0);
        send_byte(0, 8'hA2, a); check("R5 ack control byte", a, 0);
        send_byte(0, 8'hFE, a); check("R8 ack low address byte", a, 0);
        send_byte(0, 8'h11, a); check("R5 ack data 0", a, 0);
        send_byte(0, 8'h22, a); check("R5 ack data 1", a, 0);
        send_byte(0, 8'h33, a); check("R10 ack data at wrap", a, 0);
        bus_stop(0); tick(1);
        check("R3 released after stop", w_slave[0], 1);
    endtask

    task automatic t_mid_read();
        logic a, s;
        logic [7:0] b;
        bus_start(0);
        send_byte(0, 8'hA2, a);
        send_byte(0, 8'hFE, a);
        bus_start(0);
        send_byte(0, 8'hA3, a); check("R6 ack read control", a, 0);
        recv_byte(0, 1'b1, b, s);
        check("R8 read byte at 0x1FE", b, 8'h11);
        check("R5 slave low in read ack slot", s, 0);
        recv_byte(0, 1'b0, b, s);
        check("R6 host nack ignored, next byte", b, 8'h22);
        bus_stop(0);
        bus_start(0);
        send_byte(0, 8'hA1, a);
        recv_byte(0, 1'b1, b, s);
        check("R10 current read after wrap to 0", b, 8'h33);
        bus_stop(0);
    endtask

    task automatic t_abort_and_idle();
        logic a, s;
        logic [7:0] b;
        bus_start(0);
        send_byte(0, 8'hA0, a);
        send_byte(0, 8'h10, a);
        send_byte(0, 8'h5A, a);
        send_bits(0, 8'hF0, 4);
        bus_stop(0); tick(1);
        check("R3 stop mid-byte releases", w_slave[0], 1);
        bus_start(0);
        send_byte(0, 8'hA0, a);
        send_byte(0, 8'h10, a);
        bus_start(0);
        send_byte(0, 8'hA1, a);
        recv_byte(0, 1'b1, b, s);
        check("R4 MSB-first byte stored", b, 8'h5A);
        bus_stop(0);
        send_byte(0, 8'hA0, a);
        check("R3 no ack while idle", a, 1);
        scl_h[0] = 1'b1; tick(2);
    endtask

    task automatic t_small();
        logic a, s;
        logic [7:0] b;
        bus_start(1);
        send_byte(1, 8'h4A, a); check("R7 ack control with address", a, 0);
        send_byte(1, 8'h77, a); check("R7 data directly after control", a, 0);
        send_byte(1, 8'h88, a);
        bus_stop(1);
        bus_start(1);
        send_byte(1, 8'h4B, a);
        recv_byte(1, 1'b0, b, s); check("R7 read addr 0x25", b, 8'h77);
        recv_byte(1, 1'b1, b, s); check("R7 read addr 0x26", b, 8'h88);
        bus_stop(1);
        bus_start(1);
        send_byte(1, 8'hFE, a);
        send_byte(1, 8'h99, a);
        send_byte(1, 8'h66, a);
        bus_stop(1);
        bus_start(1);
        send_byte(1, 8'h01, a);
        recv_byte(1, 1'b1, b, s); check("R10 small write wrapped to 0", b, 8'h66);
        bus_stop(1);
    endtask

    task automatic t_large();
        logic a, s;
        logic [7:0] b;
        bus_start(2);
        send_byte(2, 8'hA0, a);
        send_byte(2, 8'hFF, a); check("R9 ack high address", a, 0);
        send_byte(2, 8'hFF, a); check("R9 ack low address", a, 0);
        send_byte(2, 8'hC3, a);
        send_byte(2, 8'h3C, a);
        bus_stop(2);
        bus_start(2);
        send_byte(2, 8'hA0, a);
        send_byte(2, 8'h0F, a);
        send_byte(2, 8'hFF, a);
        bus_start(2);
        send_byte(2, 8'hA1, a);
        recv_byte(2, 1'b0, b, s); check("R9 masked high byte, addr 0xFFF", b, 8'hC3);
        recv_byte(2, 1'b1, b, s); check("R10 read wraps to 0x000", b, 8'h3C);
        bus_stop(2);
    endtask

    initial begin
        for (int d = 0; d < 3; d++) begin
            scl_h[d] = 1'b1;
            sda_h[d] = 1'b1;
        end
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_mid_write();
        t_mid_read();
        t_abort_and_idle();
        t_small();
        t_large();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule